// File: doc/BRIEF.md
# SerDes Control-Register Bridge

This block turns single host requests into the bus traffic needed to reach a control register deep inside a multi-lane SerDes. The SerDes exposes its internal registers only through a small control interface (a control word, an address word and a data word), and those three words are themselves reachable only through a paged window. Every touch of one of the three words is therefore two bus cycles: a write of a page-select word to the window selector at byte offset 0x800, then the real access at the word offset inside the selected page.

A host presents a read or write with a device number, a lane, a 16-bit register address and, for writes, 16-bit data. The bridge polls the control word until the SerDes is idle, loads the address, and either starts a read and fetches the result or loads data and launches a write. Busy polls are paced by a programmable gap. A poll step that never sees the SerDes go idle ends the request with an error. One request is handled at a time, and each one ends with a one-cycle `done` pulse.

Top module: `serdes_cr_bridge`

## Requirements
- R1: Every access to a control-interface word is a bus write to offset 0x800 carrying the page word `{4'b0, dev[4:0], reg[15:9]}`. The access itself follows in the very next cycle at offset `{1'b0, reg[8:0], 2'b00}`.
- R2: The control word is register 0x80A0 (offset 0x280), the address word is 0x80A1 (offset 0x284) and the data word is 0x80A2 (offset 0x288). All three share page bits 0x40.
- R3: A read performs these steps in order: poll, write the address word, write the control word with 0x0001 (start, read), poll, read the data word.
- R4: A write performs these steps in order: poll, write the address word, write the data word, write the control word with 0x0003 (start and write). `done` rises in the cycle after that last control write, with no poll after it.
- R5: The value written to the address word is `req_addr + req_lane * 0x100`, taken modulo 2^16.
- R6: A poll reads the control word, and bit 0 of that read means busy. While busy is set the poll repeats. The strobes of two consecutive control reads are exactly `cfg_poll_gap + 4` cycles apart, using the gap value sampled when the request was accepted.
- R7: If MAX_POLLS consecutive control reads in one poll step all return busy, the request ends with `done` and `rsp_err` = 1. There is no further bus access in that request.
- R8: `req_ready` is high only when the bridge is idle. After a request is accepted it is low until the cycle in which `done` pulses. `done` is high for exactly one cycle.
- R9: On a read that ends without error, `rsp_rdata` equals the 16-bit value returned by the data-word read. It is valid with `done`, and `rsp_err` is 0.
- R10: After reset, `req_ready` is 1 and `done`, `rsp_err` and `bus_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle and accepting a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_dev | input | 5 | SerDes device number placed in the page word |
| req_lane | input | $clog2(LANES) | Lane index; adds lane * 0x100 to the address |
| req_addr | input | 16 | SerDes internal register address |
| req_wdata | input | 16 | Write data |
| cfg_poll_gap | input | GAP_W | Idle cycles inserted between busy polls |
| done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid with done |
| rsp_err | output | 1 | Busy timeout, valid with done |
| bus_valid | output | 1 | Bus strobe, one cycle per transfer |
| bus_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | 12 | Bus byte offset |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read data, valid the cycle after a read strobe |

## Verification
The bench builds the bridge with MAX_POLLS = 6, GAP_W = 4 and LANES = 4. The small poll limit puts both sides of the timeout boundary within a few dozen cycles: five busy reads followed by an idle one succeed, while six busy reads abort, in either poll of a read. The four-bit gap lets the bench sweep the whole pacing range, including a gap of zero and the maximum. With four lanes, a lane offset added to a high address wraps past 16 bits.

// File: rtl/serdes_cr_bridge.sv
module serdes_cr_bridge #(
  parameter int LANES     = 4,
  parameter int MAX_POLLS = 1024,
  parameter int GAP_W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [4:0]               req_dev,
  input  logic [$clog2(LANES)-1:0] req_lane,
  input  logic [15:0]              req_addr,
  input  logic [15:0]              req_wdata,
  input  logic [GAP_W-1:0]         cfg_poll_gap,
  output logic                     done,
  output logic [15:0]              rsp_rdata,
  output logic                     rsp_err,
  output logic                     bus_valid,
  output logic                     bus_write,
  output logic [11:0]              bus_addr,
  output logic [15:0]              bus_wdata,
  input  logic [15:0]              bus_rdata
);
  localparam int POLL_W = $clog2(MAX_POLLS);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);
  localparam logic [15:0] CR_CTL = 16'h80A0;
  localparam logic [15:0] CR_ADR = 16'h80A1;
  localparam logic [15:0] CR_DAT = 16'h80A2;
  localparam logic [11:0] WIN_SEL = 12'h800;
  localparam logic [11:0] OFF_CTL = {1'b0, CR_CTL[8:0], 2'b00};
  localparam logic [11:0] OFF_DAT = {1'b0, CR_DAT[8:0], 2'b00};

  typedef enum logic [2:0] {S_IDLE, S_PAGE, S_ACC, S_RSP, S_GAP} state_t;
  typedef enum logic [2:0] {K_POLL, K_WADR, K_WDAT, K_WCTL, K_RDAT} kind_t;

  state_t             st;
  kind_t              kind;
  logic [2:0]         sidx;
  logic               wr_q;
  logic [4:0]         dev_q;
  logic [15:0]        tgt_q, wd_q, cr_sel, acc_val;
  logic [GAP_W-1:0]   gap_q, gap_cnt;
  logic [POLL_W-1:0]  poll_cnt;
  logic               last_step;

  always_comb begin
    if (wr_q) begin
      case (sidx)
        3'd0:    kind = K_POLL;
        3'd1:    kind = K_WADR;
        3'd2:    kind = K_WDAT;
        default: kind = K_WCTL;
      endcase
    end else begin
      case (sidx)
        3'd0:    kind = K_POLL;
        3'd1:    kind = K_WADR;
        3'd2:    kind = K_WCTL;
        3'd3:    kind = K_POLL;
        default: kind = K_RDAT;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_WADR:         cr_sel = CR_ADR;
      K_WDAT, K_RDAT: cr_sel = CR_DAT;
      default:        cr_sel = CR_CTL;
    endcase
    case (kind)
      K_WADR:  acc_val = tgt_q;
      K_WDAT:  acc_val = wd_q;
      K_WCTL:  acc_val = {14'd0, wr_q, 1'b1};
      default: acc_val = 16'd0;
    endcase
  end

  assign last_step = wr_q ? (sidx == 3'd3) : (sidx == 3'd4);
  assign req_ready = (st == S_IDLE);
  assign bus_valid = (st == S_PAGE) || (st == S_ACC);
  assign bus_write = (st == S_PAGE) || ((st == S_ACC) && kind != K_POLL && kind != K_RDAT);
  assign bus_addr  = (st == S_PAGE) ? WIN_SEL : {1'b0, cr_sel[8:0], 2'b00};
  assign bus_wdata = (st == S_PAGE) ? {4'd0, dev_q, cr_sel[15:9]} : acc_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sidx      <= '0;
      wr_q      <= 1'b0;
      dev_q     <= '0;
      tgt_q     <= '0;
      wd_q      <= '0;
      gap_q     <= '0;
      gap_cnt   <= '0;
      poll_cnt  <= '0;
      done      <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      done    <= 1'b0;
      rsp_err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q     <= req_write;
          dev_q    <= req_dev;
          tgt_q    <= req_addr + (16'(req_lane) << 8);
          wd_q     <= req_wdata;
          gap_q    <= cfg_poll_gap;
          sidx     <= '0;
          poll_cnt <= '0;
          st       <= S_PAGE;
        end
        S_PAGE: st <= S_ACC;
        S_ACC: begin
          if (kind == K_POLL || kind == K_RDAT) begin
            st <= S_RSP;
          end else if (last_step) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            sidx <= sidx + 3'd1;
            st   <= S_PAGE;
          end
        end
        S_RSP: begin
          if (kind == K_RDAT) begin
            rsp_rdata <= bus_rdata;
            done      <= 1'b1;
            st        <= S_IDLE;
          end else if (bus_rdata[0]) begin
            if (poll_cnt == POLL_LAST) begin
              done    <= 1'b1;
              rsp_err <= 1'b1;
              st      <= S_IDLE;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              gap_cnt  <= gap_q;
              st       <= S_GAP;
            end
          end else begin
            poll_cnt <= '0;
            sidx     <= sidx + 3'd1;
            st       <= S_PAGE;
          end
        end
        S_GAP: begin
          if (gap_cnt == '0) st <= S_PAGE;
          else gap_cnt <= gap_cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PAGE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr != WIN_SEL) |-> $past(bus_valid && bus_write && bus_addr == WIN_SEL)); // R1
  AST_WRITE_ENDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rsp_err && wr_q) |-> $past(bus_valid && bus_write && bus_addr == OFF_CTL && bus_wdata == 16'h0003)); // R4
  AST_TIMEOUT_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(bus_valid && !bus_write && bus_addr == OFF_CTL, 2)); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_READ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rsp_err && !wr_q) |-> ($past(bus_valid && !bus_write && bus_addr == OFF_DAT, 2) && rsp_rdata == $past(bus_rdata))); // R9
endmodule

// File: tb/serdes_cr_bridge_bench.sv
module serdes_cr_bridge_bench;
  localparam int LANES = 4;
  localparam int MAXP  = 6;
  localparam int GW    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_dev = '0;
  logic [1:0] req_lane = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [GW-1:0] cfg_poll_gap = '0;
  logic req_ready, done, rsp_err, bus_valid, bus_write;
  logic [15:0] rsp_rdata, bus_wdata;
  logic [11:0] bus_addr;
  logic [15:0] bus_rdata = '0;

  serdes_cr_bridge #(.LANES(LANES), .MAX_POLLS(MAXP), .GAP_W(GW)) u_serdes_cr_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_dev(req_dev), .req_lane(req_lane), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_poll_gap(cfg_poll_gap), .done(done), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, tn = 0;
  int busy_left = 0, busy2 = 0;
  logic [15:0] areg = '0;
  logic        tr_w [256];
  logic [11:0] tr_a [256];
  logic [15:0] tr_d [256];
  int          tr_c [256];
  logic        ex_w [256];
  logic [11:0] ex_a [256];
  logic [15:0] ex_d [256];
  int en;

  function automatic logic [15:0] model_val(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (rst_n && bus_valid) begin
      tr_w[tn & 255] <= bus_write;
      tr_a[tn & 255] <= bus_addr;
      tr_d[tn & 255] <= bus_wdata;
      tr_c[tn & 255] <= cyc;
      tn <= tn + 1;
      if (bus_write) begin
        if (bus_addr == 12'h284) areg <= bus_wdata;
        if (bus_addr == 12'h280 && bus_wdata[0]) busy_left <= busy2;
      end else begin
        case (bus_addr)
          12'h280: begin
            bus_rdata <= {15'd0, busy_left != 0};
            if (busy_left != 0) busy_left <= busy_left - 1;
          end
          12'h288: bus_rdata <= model_val(areg);
          default: bus_rdata <= 16'hDEAD;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic push(input logic w, input logic [11:0] a, input logic [15:0] d);
    ex_w[en] = w; ex_a[en] = a; ex_d[en] = d; en++;
  endtask

  task automatic exp_poll(input logic [4:0] dev, input int b, inout bit to);
    int n = (b >= MAXP) ? MAXP : b + 1;
    for (int k = 0; k < n; k++) begin
      push(1'b1, 12'h800, {4'd0, dev, 7'h40});
      push(1'b0, 12'h280, 16'd0);
    end
    if (b >= MAXP) to = 1'b1;
  endtask

  task automatic run_op(input bit wr, input logic [4:0] dev, input logic [1:0] lane,
                        input logic [15:0] addr, input logic [15:0] wd,
                        input int gap, input int b0, input int b1);
    logic [15:0] tgt = addr + (16'(lane) << 8);
    logic [15:0] pg = {4'd0, dev, 7'h40};
    bit to = 1'b0;
    int base, n, bad, dc, lastc;
    logic got_err;
    logic [15:0] got_rd;
    string rq = wr ? "R4" : "R3";
    en = 0;
    exp_poll(dev, b0, to);
    if (!to) begin
      push(1'b1, 12'h800, pg); push(1'b1, 12'h284, tgt);
      if (wr) begin
        push(1'b1, 12'h800, pg); push(1'b1, 12'h288, wd);
        push(1'b1, 12'h800, pg); push(1'b1, 12'h280, 16'h0003);
      end else begin
        push(1'b1, 12'h800, pg); push(1'b1, 12'h280, 16'h0001);
        exp_poll(dev, b1, to);
        if (!to) begin push(1'b1, 12'h800, pg); push(1'b0, 12'h288, 16'd0); end
      end
    end
    @(negedge clk);
    base = tn;
    busy_left <= b0; busy2 <= b1;
    req_valid = 1'b1; req_write = wr; req_dev = dev; req_lane = lane;
    req_addr = addr; req_wdata = wd; cfg_poll_gap = GW'(gap);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = ~wr; req_addr = ~addr; cfg_poll_gap = ~GW'(gap);
    check(req_ready == 1'b0, "R8 ready low after accept", int'(req_ready), 0);
    while (done !== 1'b1) @(negedge clk);
    dc = cyc; got_err = rsp_err; got_rd = rsp_rdata;
    check(req_ready == 1'b1, "R8 ready high with done", int'(req_ready), 1);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", int'(done), 0);
    n = tn - base;
    check(n == en, {rq, " R1 R2 transfer count"}, n, en);
    bad = 0;
    for (int i = 0; i < en && i < n; i++) begin
      int j = (base + i) & 255;
      if (tr_w[j] !== ex_w[i] || tr_a[j] !== ex_a[i] || (ex_w[i] && tr_d[j] !== ex_d[i])) bad++;
      if ((i % 2) == 1 && tr_c[j] - tr_c[(base + i - 1) & 255] != 1) bad++;
    end
    check(bad == 0, {rq, " R1 R2 transfer sequence mismatches"}, bad, 0);
    bad = 0;
    for (int i = 0; i + 2 < n; i++) begin
      int j = (base + i) & 255, k = (base + i + 2) & 255;
      if (!tr_w[j] && tr_a[j] == 12'h280 && !tr_w[k] && tr_a[k] == 12'h280 &&
          tr_c[k] - tr_c[j] != gap + 4) bad++;
    end
    check(bad == 0, "R6 poll spacing mismatches", bad, 0);
    check(got_err == to, "R7 timeout flag", int'(got_err), int'(to));
    if (!to) begin
      bad = 1;
      for (int i = 0; i < n; i++) begin
        int j = (base + i) & 255;
        if (tr_w[j] && tr_a[j] == 12'h284) bad = (tr_d[j] == tgt) ? 0 : 1;
      end
      check(bad == 0, "R5 lane-adjusted address", int'(areg), int'(tgt));
    end
    lastc = tr_c[(tn - 1) & 255];
    if (wr && !to) check(dc - lastc == 1, "R4 done after control write", dc - lastc, 1);
    else check(dc - lastc == 2, {rq, " R7 done after last read"}, dc - lastc, 2);
    if (!wr && !to) check(got_rd == model_val(tgt), "R9 read data", int'(got_rd), int'(model_val(tgt)));
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && done == 1'b0 && bus_valid == 1'b0, "R10 in reset", int'({req_ready, done, bus_valid}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && done == 1'b0 && rsp_err == 1'b0 && bus_valid == 1'b0,
          "R10 after reset", int'({req_ready, done, rsp_err, bus_valid}), 8);
    run_op(1'b0, 5'd3, 2'd0, 16'h1234, 16'h0, 0, 0, 0);
    run_op(1'b1, 5'd31, 2'd1, 16'h0042, 16'hBEEF, 0, 0, 0);
    run_op(1'b0, 5'd7, 2'd3, 16'hFF80, 16'h0, 15, 2, 3);
    run_op(1'b1, 5'd1, 2'd2, 16'hFE10, 16'h55AA, 15, 3, 0);
    run_op(1'b0, 5'd9, 2'd1, 16'h2000, 16'h0, 1, 5, 5);
    run_op(1'b1, 5'd2, 2'd0, 16'h0100, 16'h0F0F, 2, 6, 0);
    run_op(1'b0, 5'd4, 2'd2, 16'h0300, 16'h0, 0, 6, 0);
    run_op(1'b0, 5'd5, 2'd3, 16'h4444, 16'h0, 3, 1, 6);
    run_op(1'b1, 5'd6, 2'd1, 16'h7777, 16'h1111, 0, 5, 0);
    for (int t = 0; t < 200; t++) begin
      int b0 = $urandom % 5, b1 = $urandom % 5;
      if (($urandom % 16) == 0) b0 = 6;
      if (($urandom % 16) == 0) b1 = 6;
      run_op(1'($urandom % 2), 5'($urandom), 2'($urandom), 16'($urandom), 16'($urandom),
             int'($urandom % 16), b0, b1);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule